// File: doc/BRIEF.md
# Stepping Servo Pan Controller

This block drives a hobby servo through a fixed panning pattern. It produces one PWM line with a 50 Hz frame. The high time of each pulse maps the commanded angle linearly onto 1 ms to 2 ms. A sequencer holds each position for a dwell interval and then moves the command one step further. After the last position of the sweep the command drops back to 0 degrees, and the pattern then starts over. The commanded angle is also brought out so that it can be observed.

The sequencer is a three-state machine:

- **PAN_DWELL** counts dwell cycles.
- When the count ends it takes the transition *advance* into **PAN_STEP** if positions remain, or the transition *wrap* into **PAN_WRAP** at the last position.
- **PAN_STEP** adds one step to the command.
- **PAN_WRAP** clears the command to zero.
- Both PAN_STEP and PAN_WRAP return to PAN_DWELL through the transition *settle*.

A pulse generator latches the pulse width for the new command only at a frame boundary. A frame timer sets the 20 ms cadence. The clock frequency, frame rate, step size, sweep end and dwell time are all parameters.

Top module: `servo_pan_ctrl`

## Requirements
- R1: The PWM frame lasts CLK_HZ/FRAME_HZ clock cycles, and `pwm_out` rises only at the first cycle of a frame.
- R2: The high time in cycles is M + (angle*M)/MAX_DEG with integer truncation, where M = CLK_HZ/1000. So 0 degrees gives 1 ms and MAX_DEG gives 2 ms.
- R3: A new command affects `pwm_out` only from the next frame start. A pulse already in progress keeps the width it started with.
- R4: With `en` high, `angle_out` grows by STEP_DEG once every D = CLK_HZ*DWELL_MS/1000 clock cycles. The first move comes D cycles after reset is released.
- R5: At the last position of the sweep (MAX_DEG by default) the next move goes to 0. Position 0 keeps a full dwell, and then stepping resumes at STEP_DEG.
- R6: While `rst` is high, `angle_out` is 0 and the dwell count is cleared. PWM frames keep running with the 0-degree pulse width.
- R7: While `en` is low, the command and the dwell count hold their values, and pulses continue at the current angle's width. The dwell then resumes where it stopped, so the next move is delayed by exactly the number of cycles `en` was low.
- R8: `angle_out` is always a multiple of STEP_DEG and never exceeds MAX_DEG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows the pan sequence to advance |
| pwm_out | output | 1 | Servo PWM line |
| angle_out | output | $clog2(MAX_DEG+1) | Commanded angle in degrees |

## Verification
The bench builds the block with CLK_HZ = 19000 and DWELL_MS = 40. This gives a 380-cycle frame, a 19-to-38-cycle pulse and a 760-cycle dwell, so a full sweep with its wrap fits in a few thousand cycles. With 19 cycles per millisecond, the width formula truncates for 30, 60, 90, 120 and 150 degrees, which exposes the rounding. The reset length is chosen so that each move lands either mid-frame after the pulse or inside a pulse. This places the frame-boundary latching rule directly under test.

// File: rtl/servo_pan_pkg.sv
package servo_pan_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        PAN_DWELL = 2'd0,
        PAN_STEP  = 2'd1,
        PAN_WRAP  = 2'd2
    } pan_state_e;

    // High time in clock cycles for a given angle: one millisecond plus the
    // angle's share of a further millisecond, truncated.
    function automatic longint pan_width_cycles(input longint clk_hz,
                                                input longint angle_deg,
                                                input longint max_deg);
        longint one_ms;
        one_ms = clk_hz / 64'd1000;
        return one_ms + (angle_deg * one_ms) / max_deg;
    endfunction

endpackage

// File: rtl/pan_frame_timer.sv
module pan_frame_timer #(
    parameter int FRAME_CYC = 2000000,
    parameter int CNT_W     = 21
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] fcnt,
    output logic             frame_last
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_CYC - 1);

    logic rst_q;
    logic rst_rise;

    // Reset restarts the frame once on assertion; frames keep running while
    // reset is held so the servo still receives its zero-degree pulse.
    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    assign rst_rise   = rst && !rst_q;
    assign frame_last = (fcnt >= LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst_rise || frame_last) begin
            fcnt <= '0;
        end else begin
            fcnt <= fcnt + 1'b1;
        end
    end

    // R1
    fcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (fcnt == '0));

endmodule

// File: rtl/pan_dwell_seq.sv
module pan_dwell_seq
    import servo_pan_pkg::*;
#(
    parameter int HOLD_CYC = 499999999,
    parameter int STEP_DEG = 30,
    parameter int NPOS     = 7,
    parameter int ANG_W    = 8,
    parameter int POS_W    = 3,
    parameter int TMR_W    = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [POS_W-1:0] pos,
    output logic [ANG_W-1:0] angle
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NPOS - 1);
    localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(HOLD_CYC - 1);
    localparam logic [ANG_W-1:0] STEP_A   = ANG_W'(STEP_DEG);
    localparam logic [ANG_W-1:0] END_A    = ANG_W'((NPOS - 1) * STEP_DEG);

    pan_state_e       st;
    pan_state_e       st_n;
    logic [TMR_W-1:0] tmr;
    logic             dwell_done;

    assign dwell_done = (tmr == TMR_END);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= PAN_DWELL;
        end else if (en) begin
            st <= st_n;
        end
    end

    // Transitions: advance / wrap out of PAN_DWELL, settle back into it
    always_comb begin
        st_n = st;
        unique case (st)
            PAN_DWELL: begin
                if (dwell_done) begin
                    st_n = (pos == LAST_POS) ? PAN_WRAP : PAN_STEP;
                end
            end
            PAN_STEP:  st_n = PAN_DWELL;
            PAN_WRAP:  st_n = PAN_DWELL;
            default:   st_n = PAN_DWELL;
        endcase
    end

    // Outputs: dwell count, position index and commanded angle
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr   <= '0;
            pos   <= '0;
            angle <= '0;
        end else if (en) begin
            unique case (st)
                PAN_DWELL: begin
                    tmr <= dwell_done ? '0 : tmr + 1'b1;
                end
                PAN_STEP: begin
                    pos   <= pos + 1'b1;
                    angle <= angle + STEP_A;
                end
                PAN_WRAP: begin
                    pos   <= '0;
                    angle <= '0;
                end
                default: begin
                    tmr <= '0;
                end
            endcase
        end
    end

    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (angle != $past(angle)) |->
            ((angle == $past(angle) + STEP_A) || (angle == '0)));

    // R5
    wrap_from_end_chk: assert property (@(posedge clk) disable iff (rst)
        ((angle == '0) && ($past(angle) != '0)) |-> ($past(pos) == LAST_POS));

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> ((angle == '0) && (pos == '0) && (tmr == '0)));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(angle) && $stable(tmr) && $stable(pos)));

    // R8
    angle_range_chk: assert property (@(posedge clk) disable iff (rst)
        angle <= END_A);

endmodule

// File: rtl/pan_pulse_gen.sv
module pan_pulse_gen
    import servo_pan_pkg::*;
#(
    parameter int CLK_HZ   = 100000000,
    parameter int STEP_DEG = 30,
    parameter int MAX_DEG  = 180,
    parameter int NPOS     = 7,
    parameter int POS_W    = 3,
    parameter int CNT_W    = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos,
    input  logic [CNT_W-1:0] fcnt,
    input  logic             frame_last,
    output logic             pwm
);

    localparam int TAB_N = 1 << POS_W;
    localparam logic [CNT_W-1:0] MAX_W =
        CNT_W'(pan_width_cycles(longint'(CLK_HZ), longint'(MAX_DEG), longint'(MAX_DEG)));

    logic [CNT_W-1:0] w_tab [TAB_N];
    logic [CNT_W-1:0] lat_w;

    // One constant width per reachable position; unused codes repeat the end.
    for (genvar g = 0; g < TAB_N; g++) begin : g_wtab
        localparam int POS_G = (g < NPOS) ? g : (NPOS - 1);
        localparam longint W_G =
            pan_width_cycles(longint'(CLK_HZ), longint'(POS_G * STEP_DEG), longint'(MAX_DEG));
        assign w_tab[g] = CNT_W'(W_G);
    end

    // Width is taken only on the last cycle of a frame, so it governs the
    // whole next frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_w <= w_tab[0];
        end else if (frame_last) begin
            lat_w <= w_tab[pos];
        end
    end

    assign pwm = (fcnt < lat_w);

    // R1
    pwm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |-> (fcnt == '0));

    // R3
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(lat_w));

    // R2
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        (fcnt >= MAX_W) |-> !pwm);

endmodule

// File: rtl/servo_pan_ctrl.sv
module servo_pan_ctrl #(
    parameter int CLK_HZ   = 100000000,
    parameter int FRAME_HZ = 50,
    parameter int STEP_DEG = 30,
    parameter int MAX_DEG  = 180,
    parameter int DWELL_MS = 5000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    output logic                         pwm_out,
    output logic [$clog2(MAX_DEG+1)-1:0] angle_out
);

    localparam int     ANG_W     = $clog2(MAX_DEG + 1);
    localparam int     FRAME_CYC = CLK_HZ / FRAME_HZ;
    localparam int     CNT_W     = $clog2(FRAME_CYC);
    localparam longint DWELL_L   = (longint'(CLK_HZ) * longint'(DWELL_MS)) / 64'd1000;
    localparam int     DWELL_CYC = int'(DWELL_L);
    localparam int     HOLD_CYC  = DWELL_CYC - 1;
    localparam int     TMR_W     = $clog2(DWELL_CYC);
    localparam int     NPOS      = MAX_DEG / STEP_DEG + 1;
    localparam int     POS_W     = (NPOS > 1) ? $clog2(NPOS) : 1;

    logic [CNT_W-1:0] fcnt;
    logic             frame_last;
    logic [POS_W-1:0] pos;
    logic [ANG_W-1:0] angle;

    pan_frame_timer #(
        .FRAME_CYC (FRAME_CYC),
        .CNT_W     (CNT_W)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .fcnt       (fcnt),
        .frame_last (frame_last)
    );

    pan_dwell_seq #(
        .HOLD_CYC (HOLD_CYC),
        .STEP_DEG (STEP_DEG),
        .NPOS     (NPOS),
        .ANG_W    (ANG_W),
        .POS_W    (POS_W),
        .TMR_W    (TMR_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .pos   (pos),
        .angle (angle)
    );

    pan_pulse_gen #(
        .CLK_HZ   (CLK_HZ),
        .STEP_DEG (STEP_DEG),
        .MAX_DEG  (MAX_DEG),
        .NPOS     (NPOS),
        .POS_W    (POS_W),
        .CNT_W    (CNT_W)
    ) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .pos        (pos),
        .fcnt       (fcnt),
        .frame_last (frame_last),
        .pwm        (pwm_out)
    );

    assign angle_out = angle;

endmodule

// File: tb/servo_pan_ctrl_bench.sv
`timescale 1ns/1ps
module servo_pan_ctrl_bench;

    localparam int CLK_HZ   = 19000;
    localparam int FRAME_HZ = 50;
    localparam int STEP_DEG = 30;
    localparam int MAX_DEG  = 180;
    localparam int DWELL_MS = 40;
    localparam int FRAME    = CLK_HZ / FRAME_HZ;
    localparam int DWELL    = CLK_HZ * DWELL_MS / 1000;
    localparam int ONE_MS   = CLK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       pwm;
    logic [7:0] angle;

    int n_chk  = 0;
    int n_fail = 0;

    int cyc = 0;
    int rise_cyc = 0, per_last = 0, hi_run = 0, w_last = 0, n_pulse = 0;
    int n_chg = 0, chg_cyc = 0, chg_prev_cyc = 0;
    logic       pwm_prev = 1'b0;
    logic [7:0] ang_prev = 8'd0;
    int c_rel = 0;

    servo_pan_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .FRAME_HZ (FRAME_HZ),
        .STEP_DEG (STEP_DEG),
        .MAX_DEG  (MAX_DEG),
        .DWELL_MS (DWELL_MS)
    ) u_servo_pan_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pwm_out   (pwm),
        .angle_out (angle)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Pulse and angle monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (pwm && !pwm_prev) begin
            per_last = cyc - rise_cyc;
            rise_cyc = cyc;
            hi_run   = 1;
        end else if (pwm) begin
            hi_run = hi_run + 1;
        end
        if (!pwm && pwm_prev) begin
            w_last  = hi_run;
            n_pulse = n_pulse + 1;
        end
        pwm_prev = pwm;
        if (angle != ang_prev) begin
            n_chg        = n_chg + 1;
            chg_prev_cyc = chg_cyc;
            chg_cyc      = cyc;
            ang_prev     = angle;
        end
    end

    function automatic int exp_w(input int a);
        return ONE_MS + (a * ONE_MS) / MAX_DEG;
    endfunction

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pulse(input string req);
        int p;
        p = n_pulse;
        for (int i = 0; i < 3000 && n_pulse == p; i++) tick;
        chk_eq(req, "pulse completed", int'(n_pulse != p), 1);
    endtask

    task automatic wait_chg(input string req);
        int c;
        c = n_chg;
        for (int i = 0; i < 5000 && n_chg == c; i++) tick;
        chk_eq(req, "angle moved", int'(n_chg != c), 1);
    endtask

    // Hold reset for k rising edges, then release with enable high
    task automatic do_reset(input int k);
        tick;
        rst = 1'b0;
        en  = 1'b0;
        tick;
        rst = 1'b1;
        repeat (k) tick;
        en    = 1'b1;
        rst   = 1'b0;
        c_rel = cyc;
    endtask

    // R6 R1 R2: pulses continue at the zero-degree width while reset is held
    task automatic t_reset_state;
        repeat (3) tick;
        chk_eq("R6", "angle under reset", int'(angle), 0);
        wait_pulse("R6");
        wait_pulse("R6");
        wait_pulse("R6");
        chk_eq("R6", "pulse width under reset", w_last, exp_w(0));
        chk_eq("R1", "frame period under reset", per_last, FRAME);
        chk_eq("R6", "angle still zero", int'(angle), 0);
    endtask

    // R4 R5 R2 R8: full sweep with wrap, move lands mid-frame after the pulse
    task automatic t_sweep;
        int ea;
        do_reset(3 * FRAME + 101);
        for (int i = 0; i < 8; i++) begin
            ea = ((i + 1) % 7) * STEP_DEG;
            wait_chg("R4");
            chk_eq("R8", "angle value", int'(angle), ea);
            if (i == 0)
                chk_eq("R4", "first move after release", chg_cyc - c_rel, DWELL);
            else if (ea == 0 || ea == STEP_DEG)
                chk_eq("R5", "dwell around wrap", chg_cyc - chg_prev_cyc, DWELL);
            else
                chk_eq("R4", "dwell length", chg_cyc - chg_prev_cyc, DWELL);
            wait_pulse("R2");
            chk_eq("R2", "pulse width for angle", w_last, exp_w(ea));
            chk_eq("R1", "frame period", per_last, FRAME);
        end
    endtask

    // R3 R6: move lands inside a pulse; that pulse keeps the old width
    task automatic t_midpulse;
        do_reset(3 * FRAME + 11);
        wait_chg("R3");
        chk_eq("R6", "dwell restarted by reset", chg_cyc - c_rel, DWELL);
        chk_eq("R3", "pulse high at move", int'(pwm), 1);
        chk_eq("R3", "angle after move", int'(angle), STEP_DEG);
        wait_pulse("R3");
        chk_eq("R3", "in-flight pulse width", w_last, exp_w(0));
        wait_pulse("R3");
        chk_eq("R3", "next frame width", w_last, exp_w(STEP_DEG));
    endtask

    // R7: freeze with enable low, pulses go on, dwell resumes
    task automatic t_enable;
        int c1, c_off, nc;
        do_reset(3 * FRAME + 101);
        wait_chg("R7");
        c1 = chg_cyc;
        repeat (200) tick;
        en    = 1'b0;
        c_off = cyc;
        nc    = n_chg;
        wait_pulse("R7");
        wait_pulse("R7");
        chk_eq("R7", "width while frozen", w_last, exp_w(STEP_DEG));
        while (cyc - c_off < 900) tick;
        chk_eq("R7", "angle frozen", int'(angle), STEP_DEG);
        chk_eq("R7", "no move while frozen", n_chg - nc, 0);
        en = 1'b1;
        wait_chg("R7");
        chk_eq("R7", "move delayed by frozen cycles", chg_cyc - c1, DWELL + 900);
        chk_eq("R7", "angle after resume", int'(angle), 2 * STEP_DEG);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state;
        t_sweep;
        t_midpulse;
        t_enable;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule